// File: doc/BRIEF.md
# Iterative Bidirectional Shifter

This block is a multi-cycle logical shifter meant to sit behind an issue manager as its functional unit. A request carries a data word, a shift amount and a direction bit. It is taken in over a valid/ready handshake on the request side. The block then moves the word one bit position per clock, with zeros entering the vacated positions. When the shift is done it presents the result on a valid/ready handshake on the result side.

Only one request is in flight at a time. The request side is ready only while the block is idle. The result is held stable until the consumer accepts it, after which the block is idle again on the next cycle. A shift amount at or above the word width gives zero. The step counter is clamped to the word width, so such a request still finishes in a bounded number of cycles.

Top module: `iter_shifter`

## Requirements
- R1: After a clock edge with `rst_n` low, `in_ready` is 1 and `out_valid` is 0, including when reset arrives in the middle of an operation.
- R2: `in_ready` is 1 only while idle, and `in_ready` and `out_valid` are never 1 together. A request is taken on a rising edge where `in_valid` and `in_ready` are both 1.
- R3: With `in_dir` = 1 the result is `in_data` shifted right logically by `in_amt`, with zeros entering at the top (13 by 2 gives 3).
- R4: With `in_dir` = 0 the result is `in_data` shifted left by `in_amt`, with zeros entering at the bottom (3 by 4 gives 48).
- R5: With `in_amt` = 0 the result equals `in_data`, and `out_valid` is 1 in the cycle right after the taking edge.
- R6: `out_valid` first goes to 1 exactly min(`in_amt`, 8) + 1 clock edges after the taking edge, counting that edge as the first.
- R7: An `in_amt` of 8 or more gives a result of 0 in either direction.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged. After an edge with both at 1, the block is idle (`in_ready` 1, `out_valid` 0).
- R9: Changes to `in_data`, `in_amt`, `in_dir` or `in_valid` while the block is busy have no effect on the pending result.
- R10: A new request may be taken on the edge right after the result has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_data | input | 8 | Word to shift |
| in_amt | input | 8 | Number of bit positions to shift |
| in_dir | input | 1 | 1 = logical right, 0 = left |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 8 | Shifted word |

## Verification
The hardest condition to reach from the ports is one where the held state could be disturbed while the block is busy. This covers a long shift with the request lines toggling underneath it, and a result held through consumer back-pressure. For each table vector, the stimulus drives junk words with `in_valid` high during every busy cycle. It keeps `out_ready` low for a chosen number of cycles while checking that the output stays stable. Separately, a reset is dropped into the middle of a long shift, and a new request is offered on the very cycle after the result is accepted.

// File: rtl/shift_pkg.sv
// Package: shared types for the iterative shifter.
// Assumes: nothing beyond IEEE 1800-2017.
package shift_pkg;

    // Control states of the shifter
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } shift_state_e;

endpackage

// File: rtl/shift_ctrl.sv
// Module: shift_ctrl
// Sequences one request: idle -> run (one step per cycle) -> done.
// Assumes: the datapath reports a zero amount at load and the final step via last_step.
module shift_ctrl
    import shift_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic amt_zero,
    input  logic last_step,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load,
    output logic step
);

    shift_state_e state_q, state_d;

    // Next-state and strobe decode
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load      = 1'b0;
        step      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    load    = 1'b1;
                    state_d = amt_zero ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                step = 1'b1;
                if (last_step) state_d = ST_DONE;
            end
            ST_DONE: begin
                out_valid = 1'b1;
                if (out_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/shift_datapath.sv
// Module: shift_datapath
// Holds the word, direction and remaining step count; moves one bit per step.
// Assumes: load and step are never high together (guaranteed by shift_ctrl).
module shift_datapath #(
    parameter int DATA_W = 8,
    parameter int AMT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [DATA_W-1:0] in_data,
    input  logic [AMT_W-1:0]  in_amt,
    input  logic              in_dir,
    output logic              amt_zero,
    output logic              last_step,
    output logic [DATA_W-1:0] result
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] word_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              dir_q;
    logic [CNT_W-1:0]  cnt_init;

    // Clamp the amount to the word width: further steps would only shift zeros
    always_comb begin
        if (in_amt >= AMT_W'(DATA_W)) cnt_init = CNT_W'(DATA_W);
        else                          cnt_init = CNT_W'(in_amt);
    end

    assign amt_zero  = (in_amt == '0);
    assign last_step = (cnt_q == CNT_W'(1));
    assign result    = word_q;

    // Word, count and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
            dir_q  <= 1'b0;
        end else if (load) begin
            word_q <= in_data;
            cnt_q  <= cnt_init;
            dir_q  <= in_dir;
        end else if (step) begin
            word_q <= dir_q ? (word_q >> 1) : (word_q << 1);
            cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/iter_shifter.sv
// Module: iter_shifter (top)
// Multi-cycle logical shifter with valid/ready on request and result sides.
// Assumes: one request in flight; latency is min(amount, DATA_W) + 1 cycles.
module iter_shifter #(
    parameter int DATA_W = 8,
    parameter int AMT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [AMT_W-1:0]  in_amt,
    input  logic              in_dir,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    logic load, step, amt_zero, last_step;

    shift_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .amt_zero  (amt_zero),
        .last_step (last_step),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load),
        .step      (step)
    );

    shift_datapath #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .in_data   (in_data),
        .in_amt    (in_amt),
        .in_dir    (in_dir),
        .amt_zero  (amt_zero),
        .last_step (last_step),
        .result    (out_data)
    );

endmodule

// File: rtl/shifter_chk.sv
// Module: shifter_chk
// Protocol and timing checks on the shifter ports; bound into iter_shifter.
// Assumes: synchronous active-low reset.
module shifter_chk #(
    parameter int DATA_W = 8,
    parameter int AMT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic [AMT_W-1:0]  in_amt,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);

    logic seen_rst;

    // Marks that at least one reset edge has occurred
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && $past(!rst_n)) |-> (in_ready && !out_valid)); // R1

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        seen_rst |-> !(in_ready && out_valid)); // R2

    AST_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_amt == '0) |=> (out_valid && out_data == $past(in_data))); // R5

    AST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_amt != '0) |=> !out_valid); // R6

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (in_ready && !out_valid)); // R8

endmodule

bind iter_shifter shifter_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_amt    (in_amt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/sim_iter_shifter.sv
`timescale 1ns/1ps
// Bench for iter_shifter: vector table walk, then directed reset and back-to-back tests.
module sim_iter_shifter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic [7:0] in_amt = '0;
    logic       in_dir = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    iter_shifter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_amt(in_amt), .in_dir(in_dir),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // {data, amount, dir, expected, consumer delay}
    localparam int NVEC = 10;
    localparam logic [28:0] VEC [NVEC] = '{
        {8'd13,  8'd2,   1'b1, 8'd3,   4'd0},   // R3
        {8'd3,   8'd4,   1'b0, 8'd48,  4'd2},   // R4
        {8'd21,  8'd0,   1'b0, 8'd21,  4'd1},   // R5
        {8'h81,  8'd1,   1'b0, 8'h02,  4'd0},   // R4
        {8'h81,  8'd1,   1'b1, 8'h40,  4'd3},   // R3
        {8'hFF,  8'd7,   1'b1, 8'h01,  4'd0},   // R3
        {8'hFF,  8'd7,   1'b0, 8'h80,  4'd4},   // R4
        {8'hA5,  8'd8,   1'b0, 8'h00,  4'd1},   // R7
        {8'hA5,  8'd200, 1'b1, 8'h00,  4'd0},   // R7
        {8'h5A,  8'd3,   1'b1, 8'h0B,  4'd2}    // R3
    };

    // Count one check, print on failure
    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Issue one request and verify latency, hold, result and release
    task automatic run_op(input logic [7:0] d, input logic [7:0] a, input logic dir,
                          input logic [7:0] exp, input int dly);
        int lat, k;
        lat = ((a > 8) ? 8 : int'(a)) + 1;
        @(negedge clk);
        check("R2 ready when idle", int'(in_ready), 1);
        in_valid = 1'b1; in_data = d; in_amt = a; in_dir = dir;
        @(posedge clk);
        k = 0;
        do begin
            @(negedge clk);
            k++;
            // R9: junk on the request side while busy
            in_valid = 1'b1; in_data = 8'(k * 37 + 5); in_amt = 8'(k); in_dir = ~dir;
        end while (!out_valid && k < 40);
        in_valid = 1'b0;
        check("R6 latency", k, lat);
        check("R3/R4/R7/R9 result", int'(out_data), int'(exp));
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            check("R8 hold valid", int'(out_valid), 1);
            check("R8 hold data", int'(out_data), int'(exp));
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R8 released", int'({in_ready, out_valid}), 2);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset ready", int'(in_ready), 1);
        check("R1 reset valid", int'(out_valid), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++)
            run_op(VEC[v][28:21], VEC[v][20:13], VEC[v][12], VEC[v][11:4], int'(VEC[v][3:0]));

        // R10: back-to-back request right after acceptance
        run_op(8'h0F, 8'd2, 1'b0, 8'h3C, 0);
        check("R10 immediate ready", int'(in_ready), 1);
        run_op(8'h0F, 8'd2, 1'b1, 8'h03, 0);

        // R1: reset in the middle of a long shift
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'hC3; in_amt = 8'd6; in_dir = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 busy not ready", int'(in_ready), 0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-op reset ready", int'(in_ready), 1);
        check("R1 mid-op reset valid", int'(out_valid), 0);
        rst_n = 1'b1;
        run_op(8'h21, 8'd0, 1'b1, 8'h21, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule